// File: doc/BRIEF.md
# T1 Transmit Payload Loopback Selector

This block sits at the end of a T1 transmit path. It chooses the source of every bit sent to the line interface and encodes the result onto a pair of rail outputs. A frame is 193 bits long: one framing bit followed by 192 payload bits. In normal operation the payload comes from the local serial input, and bit timing follows a transmit bit enable. When payload loopback is on, the block takes the payload of each received frame and sends it straight back out. Bit timing then follows the receive bit enable. The received framing bit is dropped, and a framing bit is generated locally in its place.

The framing bit follows one of two patterns. In the 24-frame extended superframe it carries a sync pattern, a CRC-6 check and a data link bit taken from an input. In the 12-frame superframe it carries a fixed pattern. The output is bipolar, with marks alternating between the two rails, or NRZ on the positive rail. Because a loopback mark is recovered from either received rail and then re-encoded, any received bipolar violation is corrected. Both bit enables are single-cycle strobes in the `clk` domain.

Top module: `t1_payload_loop_tx`

## Requirements
- R1: While reset is asserted and in the first cycle after it, line_pos, line_neg, line_stb and ch_clk are 0. The first bipolar mark sent after reset goes out on line_pos.
- R2: An "advance" is a cycle with tx_bit_en high while loop_en is 0, or with rx_bit_en high while loop_en is 1. line_stb is high exactly in the cycle after each advance. line_pos and line_neg change only in that cycle.
- R3: With loop_en at 0, a position counter decides where the framing bit falls. A framing bit goes out when the counter is 0. After any framing bit the counter becomes 1. Otherwise it counts up and wraps from 192 back to 0. Every other bit sent is the tx_ser value sampled at the advance.
- R4: With loop_en at 1, a bit goes out as a framing bit when rx_frame_strobe is high at the advance. Otherwise the bit sent is a mark if rx_pos or rx_neg was high. tx_ser has no effect on the output.
- R5: In bipolar mode, loopback marks are re-encoded in strict alternation no matter which received rail carried them. Received bipolar violations therefore never reach the line.
- R6: A frame counter starts at 0 after reset and steps once per framing bit sent. It wraps to 0 after frame 24 in ESF mode (esf_sel=1) and after frame 12 in D4 mode, and also whenever it is already past that limit. In ESF, frames 4, 8, 12, 16, 20 and 24 carry 0,0,1,0,1,1 in that order, and odd frames carry fdl_bit sampled at the advance.
- R7: The CRC-6 uses polynomial x^6+x+1 with a zero initial value. It runs over every payload bit sent, in send order, starting from one frame-1 framing bit up to the next. At that next frame-1 framing bit the result is latched and the running value is cleared. ESF frames 2, 6, 10, 14, 18 and 22 carry the latched bits, most significant first.
- R8: In D4 mode, frames 1 to 12 carry framing bits 1,0,0,0,1,1,0,1,1,1,0,0.
- R9: With nrz_sel at 1, line_pos carries the bit and line_neg is 0. With nrz_sel at 0, a 0 sends no pulse and each 1 goes to the rail opposite the previous bipolar mark.
- R10: With loop_en at 0, ch_clk is high in the cycle after the advance that sends payload position 1, 9, 17 and so on up to 185. With loop_en at 1, ch_clk stays 0.
- R11: line_pos and line_neg are never both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| loop_en | input | 1 | 1 = payload loopback |
| esf_sel | input | 1 | 1 = 24-frame ESF framing, 0 = 12-frame D4 framing |
| nrz_sel | input | 1 | 1 = NRZ output, 0 = bipolar output |
| tx_bit_en | input | 1 | Transmit bit strobe |
| tx_ser | input | 1 | Local transmit payload bit |
| fdl_bit | input | 1 | Data link bit for odd ESF frames |
| rx_bit_en | input | 1 | Receive bit strobe |
| rx_frame_strobe | input | 1 | Marks the received framing bit position |
| rx_pos | input | 1 | Received positive rail |
| rx_neg | input | 1 | Received negative rail |
| line_pos | output | 1 | Line positive rail / NRZ data |
| line_neg | output | 1 | Line negative rail |
| line_stb | output | 1 | Line bit strobe, one per sent bit |
| ch_clk | output | 1 | Channel start strobe |

## Verification
Two things can land in the same cycle. One is a loopback advance that carries a received bipolar violation, or that arrives together with the strobe replacing the received framing bit. The other is an active transmit bit enable carrying random tx_ser data, which must be ignored. The bench drives both enables at random rates in loopback, so they coincide often. It picks the received rail of each mark at random so that violations appear. It places the receive strobe at an offset unrelated to the local counter. A behavioural model predicts the rails, strobe and channel strobe every cycle, and the bench compares them. The CRC bits are judged against a polynomial long division of the queued payload, worked out separately from any shift-register form.

// File: rtl/t1lb_pkg.sv
package t1lb_pkg;
  localparam int unsigned CRC_W = 6;
  localparam logic [CRC_W-1:0] CRC_POLY = 6'b000011;
  localparam logic [11:0] D4_SEQ  = 12'b100011011100;
  localparam logic [5:0]  FPS_SEQ = 6'b001011;

  // one serial CRC-6 step, highest degree in the top bit
  function automatic logic [CRC_W-1:0] crc6_next(input logic [CRC_W-1:0] c, input logic d);
    logic fb;
    fb = c[CRC_W-1] ^ d;
    return {c[CRC_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
  endfunction

  function automatic logic d4_fbit(input logic [3:0] idx);
    return D4_SEQ[4'd11 - idx];
  endfunction

  function automatic logic fps_bit(input logic [2:0] idx);
    return FPS_SEQ[3'd5 - idx];
  endfunction

  function automatic logic crc_pick(input logic [CRC_W-1:0] c, input logic [2:0] idx);
    return c[3'd5 - idx];
  endfunction
endpackage

// File: rtl/t1lb_pos_ctr.sv
module t1lb_pos_ctr #(
  parameter int PAYLOAD_BITS = 192,
  parameter int ESF_FRAMES   = 24,
  parameter int D4_FRAMES    = 12,
  localparam int POS_W = $clog2(PAYLOAD_BITS + 1),
  localparam int FRM_W = $clog2(ESF_FRAMES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  input  logic             loop_en,
  input  logic             esf_sel,
  input  logic             rx_frame_strobe,
  output logic [POS_W-1:0] bit_pos,
  output logic [FRM_W-1:0] frm_idx,
  output logic             is_fbit,
  output logic             mf_start
);
  logic [FRM_W-1:0] frm_last;

  always_comb begin
    is_fbit  = loop_en ? rx_frame_strobe : (bit_pos == '0);
    mf_start = is_fbit && (frm_idx == '0);
    frm_last = esf_sel ? FRM_W'(ESF_FRAMES - 1) : FRM_W'(D4_FRAMES - 1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_pos <= '0;
      frm_idx <= '0;
    end else if (adv) begin
      if (is_fbit) begin
        bit_pos <= POS_W'(1);
        frm_idx <= (frm_idx >= frm_last) ? '0 : frm_idx + 1'b1;
      end else begin
        bit_pos <= (bit_pos == POS_W'(PAYLOAD_BITS)) ? '0 : bit_pos + 1'b1;
      end
    end
  end
endmodule

// File: rtl/t1lb_crc6.sv
module t1lb_crc6
  import t1lb_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pay_en,
  input  logic             pay_bit,
  input  logic             latch,
  output logic [CRC_W-1:0] crc_prev
);
  logic [CRC_W-1:0] acc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc      <= '0;
      crc_prev <= '0;
    end else if (latch) begin
      crc_prev <= acc;
      acc      <= '0;
    end else if (pay_en) begin
      acc <= crc6_next(acc, pay_bit);
    end
  end
endmodule

// File: rtl/t1lb_fbit_gen.sv
module t1lb_fbit_gen
  import t1lb_pkg::*;
#(
  parameter int D4_FRAMES = 12,
  parameter int FRM_W     = 5
) (
  input  logic             esf_sel,
  input  logic [FRM_W-1:0] frm_idx,
  input  logic [CRC_W-1:0] crc_prev,
  input  logic             fdl_bit,
  output logic             fbit
);
  logic [FRM_W-1:0] d4_idx;
  logic [2:0]       grp;

  always_comb begin
    d4_idx = (frm_idx >= FRM_W'(D4_FRAMES)) ? frm_idx - FRM_W'(D4_FRAMES) : frm_idx;
    grp    = 3'(frm_idx >> 2);
    if (!esf_sel) begin
      fbit = d4_fbit(d4_idx[3:0]);
    end else begin
      case (frm_idx[1:0])
        2'd3:    fbit = fps_bit(grp);
        2'd1:    fbit = crc_pick(crc_prev, grp);
        default: fbit = fdl_bit;
      endcase
    end
  end
endmodule

// File: rtl/t1lb_line_enc.sv
module t1lb_line_enc (
  input  logic clk,
  input  logic rst_n,
  input  logic adv,
  input  logic data_bit,
  input  logic nrz_sel,
  input  logic ch_start,
  output logic line_pos,
  output logic line_neg,
  output logic line_stb,
  output logic ch_clk
);
  logic next_neg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_pos <= 1'b0;
      line_neg <= 1'b0;
      line_stb <= 1'b0;
      ch_clk   <= 1'b0;
      next_neg <= 1'b0;
    end else if (adv) begin
      line_stb <= 1'b1;
      ch_clk   <= ch_start;
      if (nrz_sel) begin
        line_pos <= data_bit;
        line_neg <= 1'b0;
      end else if (data_bit) begin
        line_pos <= !next_neg;
        line_neg <= next_neg;
        next_neg <= !next_neg;
      end else begin
        line_pos <= 1'b0;
        line_neg <= 1'b0;
      end
    end else begin
      line_stb <= 1'b0;
      ch_clk   <= 1'b0;
    end
  end
endmodule

// File: rtl/t1_payload_loop_tx.sv
module t1_payload_loop_tx
  import t1lb_pkg::*;
#(
  parameter int PAYLOAD_BITS = 192,
  parameter int CH_BITS      = 8,
  parameter int ESF_FRAMES   = 24,
  parameter int D4_FRAMES    = 12
) (
  input  logic clk,
  input  logic rst_n,
  input  logic loop_en,
  input  logic esf_sel,
  input  logic nrz_sel,
  input  logic tx_bit_en,
  input  logic tx_ser,
  input  logic fdl_bit,
  input  logic rx_bit_en,
  input  logic rx_frame_strobe,
  input  logic rx_pos,
  input  logic rx_neg,
  output logic line_pos,
  output logic line_neg,
  output logic line_stb,
  output logic ch_clk
);
  localparam int POS_W = $clog2(PAYLOAD_BITS + 1);
  localparam int FRM_W = $clog2(ESF_FRAMES);

  // named internal events
  logic             adv;
  logic             is_fbit;
  logic             mf_start;
  logic             mark_lb;
  logic             pay_bit;
  logic             fbit;
  logic             data_bit;
  logic             ch_start;
  logic [POS_W-1:0] bit_pos;
  logic [FRM_W-1:0] frm_idx;
  logic [CRC_W-1:0] crc_prev;

  always_comb begin
    adv      = loop_en ? rx_bit_en : tx_bit_en;
    mark_lb  = rx_pos | rx_neg;
    pay_bit  = loop_en ? mark_lb : tx_ser;
    data_bit = is_fbit ? fbit : pay_bit;
    ch_start = !loop_en && !is_fbit &&
               (((bit_pos - POS_W'(1)) % POS_W'(CH_BITS)) == '0);
  end

  t1lb_pos_ctr #(
    .PAYLOAD_BITS(PAYLOAD_BITS),
    .ESF_FRAMES  (ESF_FRAMES),
    .D4_FRAMES   (D4_FRAMES)
  ) u_pos (
    .clk            (clk),
    .rst_n          (rst_n),
    .adv            (adv),
    .loop_en        (loop_en),
    .esf_sel        (esf_sel),
    .rx_frame_strobe(rx_frame_strobe),
    .bit_pos        (bit_pos),
    .frm_idx        (frm_idx),
    .is_fbit        (is_fbit),
    .mf_start       (mf_start)
  );

  t1lb_crc6 u_crc (
    .clk     (clk),
    .rst_n   (rst_n),
    .pay_en  (adv && !is_fbit),
    .pay_bit (pay_bit),
    .latch   (adv && mf_start),
    .crc_prev(crc_prev)
  );

  t1lb_fbit_gen #(
    .D4_FRAMES(D4_FRAMES),
    .FRM_W    (FRM_W)
  ) u_fbit (
    .esf_sel (esf_sel),
    .frm_idx (frm_idx),
    .crc_prev(crc_prev),
    .fdl_bit (fdl_bit),
    .fbit    (fbit)
  );

  t1lb_line_enc u_enc (
    .clk     (clk),
    .rst_n   (rst_n),
    .adv     (adv),
    .data_bit(data_bit),
    .nrz_sel (nrz_sel),
    .ch_start(ch_start),
    .line_pos(line_pos),
    .line_neg(line_neg),
    .line_stb(line_stb),
    .ch_clk  (ch_clk)
  );
endmodule

// File: rtl/t1lb_checker.sv
module t1lb_checker (
  input logic clk,
  input logic rst_n,
  input logic loop_en,
  input logic nrz_sel,
  input logic tx_bit_en,
  input logic rx_bit_en,
  input logic rx_frame_strobe,
  input logic rx_pos,
  input logic rx_neg,
  input logic line_pos,
  input logic line_neg,
  input logic line_stb,
  input logic ch_clk
);
  logic nrz_d, lb_d, strb_d, mark_d, exp_neg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nrz_d   <= 1'b0;
      lb_d    <= 1'b0;
      strb_d  <= 1'b0;
      mark_d  <= 1'b0;
      exp_neg <= 1'b0;
    end else begin
      nrz_d  <= nrz_sel;
      lb_d   <= loop_en;
      strb_d <= rx_frame_strobe;
      mark_d <= rx_pos | rx_neg;
      if (line_stb && !nrz_d && (line_pos || line_neg)) exp_neg <= !exp_neg;
    end
  end

  a_r11_rails_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(line_pos && line_neg));

  a_r10_chclk_quiet_loop: assert property (@(posedge clk) disable iff (!rst_n)
    loop_en |=> !ch_clk);

  a_r2_no_stb_tx: assert property (@(posedge clk) disable iff (!rst_n)
    (!loop_en && !tx_bit_en) |=> !line_stb);

  a_r2_no_stb_rx: assert property (@(posedge clk) disable iff (!rst_n)
    (loop_en && !rx_bit_en) |=> !line_stb);

  a_r2_rails_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !line_stb |-> ($stable(line_pos) && $stable(line_neg)));

  a_r9_nrz_neg_low: assert property (@(posedge clk) disable iff (!rst_n)
    (line_stb && nrz_d) |-> !line_neg);

  a_r4_loop_payload: assert property (@(posedge clk) disable iff (!rst_n)
    (line_stb && lb_d && !strb_d) |-> ((line_pos || line_neg) == mark_d));

  a_r5_alternation: assert property (@(posedge clk) disable iff (!rst_n)
    (line_stb && !nrz_d && (line_pos || line_neg)) |-> (line_pos == !exp_neg));
endmodule

bind t1_payload_loop_tx t1lb_checker u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .loop_en        (loop_en),
  .nrz_sel        (nrz_sel),
  .tx_bit_en      (tx_bit_en),
  .rx_bit_en      (rx_bit_en),
  .rx_frame_strobe(rx_frame_strobe),
  .rx_pos         (rx_pos),
  .rx_neg         (rx_neg),
  .line_pos       (line_pos),
  .line_neg       (line_neg),
  .line_stb       (line_stb),
  .ch_clk         (ch_clk)
);

// File: tb/sim_t1_payload_loop_tx.sv
`timescale 1ns/1ps
module sim_t1_payload_loop_tx;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic loop_en = 0, esf_sel = 0, nrz_sel = 0;
  logic tx_bit_en = 0, tx_ser = 0, fdl_bit = 0;
  logic rx_bit_en = 0, rx_frame_strobe = 0, rx_pos = 0, rx_neg = 0;
  logic line_pos, line_neg, line_stb, ch_clk;

  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  t1_payload_loop_tx u0 (
    .clk(clk), .rst_n(rst_n), .loop_en(loop_en), .esf_sel(esf_sel),
    .nrz_sel(nrz_sel), .tx_bit_en(tx_bit_en), .tx_ser(tx_ser),
    .fdl_bit(fdl_bit), .rx_bit_en(rx_bit_en),
    .rx_frame_strobe(rx_frame_strobe), .rx_pos(rx_pos), .rx_neg(rx_neg),
    .line_pos(line_pos), .line_neg(line_neg), .line_stb(line_stb),
    .ch_clk(ch_clk)
  );

  // ---------------- behavioural reference ----------------
  int     m_pos = 0, m_frm = 0;
  bit     m_next_neg = 0;
  bit     e_pos = 0, e_neg = 0, e_stb = 0, e_ch = 0;
  string  e_tag = "R1";
  int     pay_q[$];
  bit [5:0] m_crc = '0;
  bit     first_mark_done = 0;

  // remainder of M(x)*x^6 divided by x^6+x+1, first bit = highest degree
  function automatic bit [5:0] long_div(input int bits[$]);
    int a[$];
    int g[7] = '{1, 0, 0, 0, 0, 1, 1};
    bit [5:0] r;
    a = bits;
    for (int i = 0; i < 6; i++) a.push_back(0);
    for (int i = 0; i < bits.size(); i++)
      if (a[i] == 1)
        for (int k = 0; k < 7; k++) a[i+k] = a[i+k] ^ g[k];
    for (int k = 0; k < 6; k++) r[5-k] = a[bits.size()+k][0];
    return r;
  endfunction

  task automatic model_step();
    bit adv, isf, d;
    int n, last;
    string fps = "001011";
    string d4  = "100011011100";
    adv = loop_en ? rx_bit_en : tx_bit_en;
    e_stb = adv;
    if (!adv) begin
      e_ch = 0;
      return;
    end
    isf = loop_en ? rx_frame_strobe : (m_pos == 0);
    if (isf) begin
      if (m_frm == 0) begin
        m_crc = long_div(pay_q);
        pay_q.delete();
      end
      n = m_frm + 1;
      if (esf_sel) begin
        if (n % 4 == 0) begin d = (fps[n/4-1] == "1"); e_tag = "R6"; end
        else if (n % 4 == 2) begin d = m_crc[5-(n-2)/4]; e_tag = "R7"; end
        else begin d = fdl_bit; e_tag = "R6"; end
      end else begin
        d = (d4[m_frm % 12] == "1");
        e_tag = "R8";
      end
      last = esf_sel ? 23 : 11;
      m_frm = (m_frm >= last) ? 0 : m_frm + 1;
      m_pos = 1;
      e_ch = 0;
    end else begin
      d = loop_en ? (rx_pos | rx_neg) : tx_ser;
      pay_q.push_back(int'(d));
      e_ch = !loop_en && ((m_pos - 1) % 8 == 0);
      m_pos = (m_pos == 192) ? 0 : m_pos + 1;
      if (nrz_sel) e_tag = loop_en ? "R4" : "R9";
      else         e_tag = loop_en ? "R5" : "R3";
    end
    if (nrz_sel) begin
      e_pos = d; e_neg = 0;
    end else if (d) begin
      e_pos = !m_next_neg; e_neg = m_next_neg;
      m_next_neg = !m_next_neg;
    end else begin
      e_pos = 0; e_neg = 0;
    end
  endtask

  always @(posedge clk) if (rst_n) model_step();

  // ---------------- checking ----------------
  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic compare();
    string t;
    check(line_stb == e_stb, "R2", line_stb, e_stb);
    t = e_stb ? e_tag : "R2";
    check({line_pos, line_neg} == {e_pos, e_neg}, t,
          int'({line_pos, line_neg}), int'({e_pos, e_neg}));
    check(ch_clk == e_ch, "R10", ch_clk, e_ch);
    check(!(line_pos && line_neg), "R11", int'({line_pos, line_neg}), 0);
    if (!first_mark_done && line_stb && !nrz_sel && (line_pos || line_neg)) begin
      first_mark_done = 1;
      check(line_pos == 1'b1, "R1", line_pos, 1);
    end
  endtask

  int rx_cnt = 0;

  task automatic run(input int cycles, input bit lb, input bit esf, input bit nrz,
                     input int tx_rate, input int rx_rate);
    for (int c = 0; c < cycles; c++) begin
      @(negedge clk);
      compare();
      loop_en = lb; esf_sel = esf; nrz_sel = nrz;
      tx_bit_en = ($urandom % tx_rate) == 0;
      tx_ser    = $urandom % 2;
      fdl_bit   = $urandom % 2;
      rx_bit_en = ($urandom % rx_rate) == 0;
      rx_frame_strobe = 0; rx_pos = 0; rx_neg = 0;
      if (rx_bit_en) begin
        rx_frame_strobe = (rx_cnt % 193) == 0;
        rx_cnt++;
        if ($urandom % 2) begin
          if ($urandom % 2) rx_pos = 1; else rx_neg = 1;
        end
      end
    end
  endtask

  initial begin
    repeat (4) @(negedge clk);
    // R1: reset state
    check(!line_pos && !line_neg, "R1", int'({line_pos, line_neg}), 0);
    check(!line_stb && !ch_clk, "R1", int'({line_stb, ch_clk}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!line_stb && !line_pos && !line_neg && !ch_clk, "R1",
          int'({line_stb, line_pos, line_neg, ch_clk}), 0);
    run(20000, 0, 1, 0, 2, 3);   // normal ESF bipolar, R3 R6 R7
    run(3000,  0, 0, 1, 1, 3);   // normal D4 NRZ, R8 R9
    rx_cnt = 50;                 // loopback entry mid-frame
    run(21000, 1, 1, 0, 1, 2);   // loopback ESF bipolar, R4 R5 R7
    run(3000,  1, 0, 1, 1, 1);   // loopback D4 NRZ, R4 R8
    run(3000,  0, 1, 0, 2, 2);   // back to normal
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL R2: watchdog actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule